// File: doc/BRIEF.md
# Receive Character Buffer with Threshold and Timeout Interrupts

This block is the receive-side character store of a 16550-style serial port. A receive deserializer hands it one character at a time together with the configured word length. The block keeps up to 16 characters in arrival order and returns them through a single receive-data read port. Each read delivers the oldest character and removes it. Software never addresses the storage directly. It sees only the head entry.

Two interrupt causes are produced. A level interrupt fires when the number of stored characters reaches a selectable threshold, so software can drain a batch with one service call. A timeout interrupt covers a partial batch that never reaches the threshold: the buffer holds something and has seen no write or read for three and a half character times. A priority encoder reports the pending cause as a 4-bit identification code with an active-low pending bit.

The input side is a valid/ready stream. `in_ready` is low while all 16 entries are occupied. The deserializer cannot stall the line, so a beat offered while `in_ready` is low is not held back: it is dropped and recorded in a sticky overrun flag. A pop in the same cycle does not make room for a beat offered to a full buffer. The read side is plain: `rd_valid` shows that the head is meaningful, and `rd_en` pops it.

Top module: `rx_batch_buffer`

## Requirements
- R1: Each cycle with `rd_en` high and `rd_valid` high pops the head entry. Successive pops return the characters in the order they were accepted. `rd_data` reads 0 when the buffer is empty, and a read of an empty buffer changes nothing.
- R2: A stored character keeps only its low 5+`word_len` bits, with the rest forced to zero (`word_len` 00=5, 01=6, 10=7, 11=8 bits). Bit 0 is the first data bit off the line.
- R3: The threshold is chosen by `trig_sel`: 00 gives 1, 01 gives 4, 10 gives 8 and 11 gives 14 characters. With `rx_irq_en` high and the fill at or above the threshold, `irq_id` is 4'b0100, meaning cause 2 in bits 3:1 with bit 0 low.
- R4: The idle counter advances on `baud_tick`. It restarts on every accepted write, every pop, on `fifo_clr`, and whenever the buffer is empty. It expires at 56×(7+`word_len`) ticks. With the fill between 1 and threshold−1, `rx_irq_en` high and the counter expired, `irq_id` is 4'b1100, meaning cause 6.
- R5: The level cause has priority over the timeout cause. With no cause pending, `irq_id` is 4'b0001 and `irq` is low. `irq` equals the inverse of `irq_id[0]`. Both causes clear by themselves once their condition stops holding.
- R6: A beat offered while the buffer holds 16 characters is discarded and sets `overrun`. `status_rd` clears `overrun`, but a new overrun in the same cycle keeps it set.
- R7: `fifo_clr` empties the buffer and restarts the idle counter in one cycle. A write in that cycle is dropped. `trig_sel` and `overrun` are unaffected.
- R8: `in_ready` is high exactly when fewer than 16 characters are stored.
- R9: With `rx_irq_en` low, `irq_id` is 4'b0001 whatever the fill or the idle counter.
- R10: After reset the buffer is empty, `overrun` is low, `irq_id` is 4'b0001 and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Deserializer offers a character |
| in_ready | output | 1 | Buffer has room for a character |
| in_data | input | 8 | Received character, bit 0 first on the line |
| word_len | input | 2 | Data bits per character: 00=5 through 11=8 |
| baud_tick | input | 1 | One pulse per 16x baud period |
| trig_sel | input | 2 | Level threshold select |
| rx_irq_en | input | 1 | Receive interrupt enable |
| fifo_clr | input | 1 | Empty the buffer |
| rd_en | input | 1 | Read of the receive-data register (pops the head) |
| rd_valid | output | 1 | Buffer is not empty |
| rd_data | output | 8 | Oldest character, or 0 when empty |
| status_rd | input | 1 | Read of the status that holds the overrun flag |
| overrun | output | 1 | Sticky overrun flag |
| irq_id | output | 4 | Pending cause in bits 3:1, bit 0 low when pending |
| irq | output | 1 | Receive interrupt request |

## Verification
A wrong pointer or count shows at `rd_data` or `rd_valid` on the next read: characters come back out of order, repeated, or missing. The same fault moves `in_ready` and the level cause in `irq_id` in the cycle after the write or pop that caused it. A wrong idle counter appears only as a timeout code that comes too early or too late. For that reason the bench holds the buffer partly filled across the full 392-tick and 560-tick windows and compares `irq_id` on every cycle, so the error is caught in the exact cycle it occurs. Overrun and clear faults show up in the cycle after the beat that is dropped, or after the clear.

// File: rtl/rxb_pkg.sv
package rxb_pkg;
  localparam int unsigned DATA_W   = 8;
  localparam int unsigned DEPTH    = 16;
  localparam int unsigned TICKS_X2 = 56;        // 3.5 char times of 16 ticks per bit
  localparam int unsigned MAX_FRAME = 10;       // start + 8 data + stop
  localparam int unsigned TMR_W    = $clog2(TICKS_X2 * MAX_FRAME + 1);

  typedef enum logic [3:0] {
    IRQ_NONE  = 4'b0001,
    IRQ_LEVEL = 4'b0100,
    IRQ_IDLE  = 4'b1100
  } irq_code_e;

  function automatic logic [4:0] level_for(input logic [1:0] sel);
    case (sel)
      2'b00:   level_for = 5'd1;
      2'b01:   level_for = 5'd4;
      2'b10:   level_for = 5'd8;
      default: level_for = 5'd14;
    endcase
  endfunction

  function automatic logic [TMR_W-1:0] idle_limit(input logic [1:0] wl);
    idle_limit = TMR_W'(TICKS_X2 * (7 + int'(wl)));
  endfunction
endpackage

// File: rtl/rxb_store.sv
module rxb_store #(
  parameter int unsigned DEPTH  = 16,
  parameter int unsigned DATA_W = 8,
  localparam int unsigned AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CW    = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              push,
  input  logic              pop,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic [CW-1:0]     fill,
  output logic              full,
  output logic              empty,
  output logic              push_acc,
  output logic              pop_acc
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic [AW-1:0]     wr_ptr, rd_ptr;

  assign full     = (fill == CW'(DEPTH));
  assign empty    = (fill == '0);
  assign push_acc = push && !full && !clr;
  assign pop_acc  = pop && !empty && !clr;
  assign rdata    = empty ? '0 : mem[rd_ptr];

  function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
    step = (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      fill   <= '0;
    end else if (clr) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      fill   <= '0;
    end else begin
      if (push_acc) wr_ptr <= step(wr_ptr);
      if (pop_acc)  rd_ptr <= step(rd_ptr);
      case ({push_acc, pop_acc})
        2'b10:   fill <= fill + 1'b1;
        2'b01:   fill <= fill - 1'b1;
        default: fill <= fill;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (push_acc) mem[wr_ptr] <= wdata;
  end
endmodule

// File: rtl/rxb_idle_timer.sv
module rxb_idle_timer #(
  parameter int unsigned TW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart,
  input  logic          tick,
  input  logic [TW-1:0] limit,
  output logic          expired
);
  logic [TW-1:0] cnt;

  assign expired = (cnt >= limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt <= '0;
    else if (restart)          cnt <= '0;
    else if (tick && !expired) cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/rxb_irq_enc.sv
module rxb_irq_enc #(
  parameter int unsigned CW = 5
) (
  input  logic [CW-1:0] fill,
  input  logic [1:0]    trig_sel,
  input  logic          enable,
  input  logic          idle_expired,
  output logic [3:0]    irq_id,
  output logic          irq
);
  import rxb_pkg::*;
  logic [CW-1:0] thr;
  logic          lvl_hit, idle_hit;

  assign thr      = CW'(level_for(trig_sel));
  assign lvl_hit  = enable && (fill >= thr);
  assign idle_hit = enable && (fill != '0) && idle_expired;

  always_comb begin
    if (lvl_hit)       irq_id = IRQ_LEVEL;
    else if (idle_hit) irq_id = IRQ_IDLE;
    else               irq_id = IRQ_NONE;
  end
  assign irq = !irq_id[0];
endmodule

// File: rtl/rx_batch_buffer.sv
module rx_batch_buffer (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  output logic       in_ready,
  input  logic [7:0] in_data,
  input  logic [1:0] word_len,
  input  logic       baud_tick,
  input  logic [1:0] trig_sel,
  input  logic       rx_irq_en,
  input  logic       fifo_clr,
  input  logic       rd_en,
  output logic       rd_valid,
  output logic [7:0] rd_data,
  input  logic       status_rd,
  output logic       overrun,
  output logic [3:0] irq_id,
  output logic       irq
);
  import rxb_pkg::*;
  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic [DATA_W-1:0] masked;
  logic [CW-1:0]     fill;
  logic              full, empty, push_acc, pop_acc, expired;

  // keep only the configured number of data bits
  for (genvar b = 0; b < DATA_W; b++) begin : g_mask
    if (b < 5) begin : g_always
      assign masked[b] = in_data[b];
    end else begin : g_cond
      assign masked[b] = in_data[b] && (int'(word_len) >= b - 4);
    end
  end

  rxb_store #(.DEPTH(DEPTH), .DATA_W(DATA_W)) i_store (
    .clk, .rst_n, .clr(fifo_clr), .push(in_valid), .pop(rd_en),
    .wdata(masked), .rdata(rd_data), .fill, .full, .empty,
    .push_acc, .pop_acc
  );

  rxb_idle_timer #(.TW(TMR_W)) i_timer (
    .clk, .rst_n,
    .restart(fifo_clr || push_acc || pop_acc || empty),
    .tick(baud_tick), .limit(idle_limit(word_len)), .expired
  );

  rxb_irq_enc #(.CW(CW)) i_enc (
    .fill, .trig_sel, .enable(rx_irq_en), .idle_expired(expired),
    .irq_id, .irq
  );

  assign in_ready = !full;
  assign rd_valid = !empty;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                overrun <= 1'b0;
    else if (in_valid && full && !fifo_clr)    overrun <= 1'b1;
    else if (status_rd)                        overrun <= 1'b0;
  end
endmodule

// File: rtl/rx_batch_checker.sv
module rx_batch_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       in_valid,
  input logic       in_ready,
  input logic       fifo_clr,
  input logic       rd_en,
  input logic       rd_valid,
  input logic       rx_irq_en,
  input logic [1:0] trig_sel,
  input logic [4:0] fill,
  input logic       overrun,
  input logic [3:0] irq_id,
  input logic       irq
);
  import rxb_pkg::*;

  // R1: a lone pop lowers the stored count by one
  a_r1_pop_count: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_valid && !in_valid && !fifo_clr) |=> (fill == $past(fill) - 5'd1));

  // R3: level reached with enable gives the level code
  a_r3_level_code: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_irq_en && fill >= level_for(trig_sel)) |-> (irq_id == 4'b0100));

  // R5: only three codes ever appear, and irq mirrors bit 0
  a_r5_code_legal: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_id == 4'b0001 || irq_id == 4'b0100 || irq_id == 4'b1100) && (irq == !irq_id[0]));

  // R6: a beat dropped on a full buffer sets overrun
  a_r6_overrun_set: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_ready && !fifo_clr) |=> overrun);

  // R7: clear leaves the buffer empty
  a_r7_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_clr |=> (!rd_valid && fill == 5'd0));

  // R8: ready falls only at the full count
  a_r8_ready_full: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_ready) |-> (fill == 5'(DEPTH)));

  // R9: disabled interrupts report nothing pending
  a_r9_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_irq_en) |-> (irq_id == 4'b0001));
endmodule

bind rx_batch_buffer rx_batch_checker i_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .fifo_clr(fifo_clr), .rd_en(rd_en), .rd_valid(rd_valid),
  .rx_irq_en(rx_irq_en), .trig_sel(trig_sel), .fill(fill),
  .overrun(overrun), .irq_id(irq_id), .irq(irq)
);

// File: tb/test_rx_batch_buffer.sv
module test_rx_batch_buffer;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 0, baud_tick = 0, rx_irq_en = 0, fifo_clr = 0, rd_en = 0, status_rd = 0;
  logic [7:0] in_data = 0;
  logic [1:0] word_len = 2'b11, trig_sel = 2'b00;
  logic       in_ready, rd_valid, overrun, irq;
  logic [7:0] rd_data;
  logic [3:0] irq_id;

  int compared = 0, mismatched = 0;
  bit done = 0;

  logic [7:0] q[$];
  int  tmr = 0;
  bit  m_ovr = 0;

  always #10 clk = ~clk;

  rx_batch_buffer i_rx_batch_buffer (
    .clk, .rst_n, .in_valid, .in_ready, .in_data, .word_len, .baud_tick,
    .trig_sel, .rx_irq_en, .fifo_clr, .rd_en, .rd_valid, .rd_data,
    .status_rd, .overrun, .irq_id, .irq
  );

  function automatic int thr_of(input logic [1:0] s);
    return (s == 0) ? 1 : (s == 1) ? 4 : (s == 2) ? 8 : 14;
  endfunction

  function automatic logic [3:0] exp_id();
    if (rx_irq_en && q.size() >= thr_of(trig_sel)) return 4'b0100;
    if (rx_irq_en && q.size() > 0 && tmr >= 56 * (7 + int'(word_len))) return 4'b1100;
    return 4'b0001;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s at %0t: actual %0h expected %0h", req, $time, act, exp);
    end
  endtask

  // one clock: compare before the edge, update the model at the edge
  task automatic cyc();
    logic [7:0] head;
    bit pop, push_ok, set_ovr;
    #8;
    head = (q.size() > 0) ? q[0] : 8'h00;
    chk("R1 rd_data", rd_data, head);
    chk("R1 rd_valid", rd_valid, q.size() > 0);
    chk("R8 in_ready", in_ready, q.size() < 16);
    chk("R6 overrun", overrun, m_ovr);
    chk("R4 irq_id", irq_id, exp_id());
    chk("R5 irq", irq, exp_id() != 4'b0001);
    @(posedge clk);
    set_ovr = in_valid && q.size() == 16 && !fifo_clr;
    pop     = rd_en && q.size() > 0 && !fifo_clr;
    push_ok = in_valid && q.size() < 16 && !fifo_clr;
    if (fifo_clr || pop || push_ok || q.size() == 0) tmr = 0;
    else if (baud_tick && tmr < 56 * (7 + int'(word_len))) tmr++;
    if (fifo_clr) q.delete();
    else begin
      if (pop) void'(q.pop_front());
      if (push_ok) q.push_back(in_data & (8'hFF >> (3 - int'(word_len))));
    end
    if (set_ovr) m_ovr = 1;
    else if (status_rd) m_ovr = 0;
    @(negedge clk);
    in_valid = 0; rd_en = 0; fifo_clr = 0; status_rd = 0;
  endtask

  task automatic put(input logic [7:0] d);
    in_valid = 1; in_data = d; cyc();
  endtask

  task automatic get();
    rd_en = 1; cyc();
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc();
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      mismatched++;
      compared++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    logic [15:0] lfsr = 16'hACE1;
    repeat (3) @(negedge clk);
    rst_n = 1;
    idle(2);                                      // R10 reset state
    rx_irq_en = 1; trig_sel = 2'b00;
    put(8'hA5); idle(1); get();                   // R3 threshold 1
    word_len = 2'b00; put(8'hFF); word_len = 2'b01; put(8'hFF);
    word_len = 2'b10; put(8'hFF); word_len = 2'b11; put(8'h81);  // R2 masking
    repeat (5) get();                             // R1 extra read on empty
    trig_sel = 2'b11;
    for (int i = 0; i < 14; i++) put(8'(i * 17 + 3));  // R3 reached on 14th
    trig_sel = 2'b10; idle(1); trig_sel = 2'b01; idle(1); trig_sel = 2'b11;
    repeat (14) get();                            // R1 order
    baud_tick = 1;
    put(8'h11); put(8'h22); idle(565);            // R4 timeout at 560
    get(); idle(3);                               // R5 auto clear
    word_len = 2'b00; idle(400);                  // R4 shorter window 392
    trig_sel = 2'b00; idle(2); trig_sel = 2'b11;  // R5 level wins
    rx_irq_en = 0; idle(3); rx_irq_en = 1;        // R9 gating
    word_len = 2'b11; get(); idle(2);
    for (int i = 0; i < 18; i++) put(8'(200 - i));  // R6 overrun, R8 full
    status_rd = 1; cyc(); idle(1);                // R6 clear on read
    in_valid = 1; in_data = 8'h55; status_rd = 1; cyc();  // R6 set beats clear
    in_valid = 1; fifo_clr = 1; cyc(); idle(2);   // R7 clear, trig kept
    put(8'h3C); idle(2); get();
    for (int i = 0; i < 600; i++) begin           // mixed traffic
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      in_valid  = lfsr[0] | lfsr[5];
      rd_en     = lfsr[1] & lfsr[3];
      in_data   = lfsr[15:8];
      word_len  = (i % 150 == 0) ? lfsr[7:6] : word_len;
      trig_sel  = (i % 97 == 0) ? lfsr[4:3] : trig_sel;
      fifo_clr  = (lfsr[15:11] == 5'd7);
      status_rd = lfsr[2] & lfsr[9];
      baud_tick = lfsr[6] | lfsr[12];
      cyc();
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule